// File: doc/BRIEF.md
# Exception entry sequencer

This block starts exception handling for a processor core. It takes three request sources: an error on the data bus, an error on an instruction fetch, and a non-maskable interrupt line. It holds each request in a pending flag and picks one request at a time by fixed priority. It then saves the return address and the old status word on the system stack through a word-write port that waits for a ready signal. At the end it presents the new stack pointer, a rewritten status word and the handler address. The handler address is a vector base plus an offset that depends on the source.

Bus errors are entered at once. The saved return address is the address of the first instruction not yet issued. For the interrupt, the pipeline first completes the instructions it already holds. The block asks for this with a drain request. The saved address is then the address of the first instruction that did not complete. The interrupt line is edge-captured. It is not masked by the global mask bit. It is refused while the current mode field already shows interrupt service, so interrupt entries never nest. A one-cycle done pulse marks the cycle in which the new values are valid. The core loads them in that cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: On done, `pc_o` equals `evba_i` plus 0x08 for a data bus error, 0x0C for a fetch bus error and 0x10 for the interrupt.
- R2: Each entry makes exactly two stack writes. The first goes to `sp_i`-4 and carries the return address. The second goes to `sp_i`-8 and carries the status word as it was at selection. On done, `sp_o` equals `sp_i`-8.
- R3: The status word on done is the old word with bit 15 and bit 28 cleared and bit 16 and bit 21 set. All other bits outside the mode field (bits 24:22) are unchanged.
- R4: The mode field of `sr_o` on done is 3'b110 for both bus errors and 3'b111 for the interrupt.
- R5: An interrupt is entered even when bit 16 of `sr_i` (the global mask) is 1.
- R6: A rising edge on `nmi_i` while `sr_i[24:22]` is 3'b111 is dropped. It causes no drain request, no stack write and no done pulse, then or later.
- R7: For a bus error, the return address is `pc_noissue_i`. No drain request is raised.
- R8: For the interrupt, `drain_req_o` stays high until `drained_i` is seen. No stack write happens before that. The return address is the value of `pc_nocomplete_i` in the cycle in which `drained_i` is accepted.
- R9: Requests pending together are served in the order data bus error, fetch bus error, interrupt. A request that loses the choice stays pending and is served later.
- R10: While `mem_we_o` is high and `mem_rdy_i` is low, the write stays asserted with stable address and data.
- R11: `done_o` is a single-cycle pulse. After reset, `done_o`, `mem_we_o` and `drain_req_o` are low.
- R12: The interrupt is taken on a rising edge only. A line that stays high causes no second entry.
- R13: A request that arrives while an entry is in progress is held and served after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dbus_err_i | input | 1 | Data bus error request pulse |
| ibus_err_i | input | 1 | Fetch bus error request pulse |
| nmi_i | input | 1 | Non-maskable interrupt line, edge-captured |
| sr_i | input | XLEN | Current status word |
| sp_i | input | XLEN | Current system stack pointer |
| evba_i | input | XLEN | Exception vector base |
| pc_noissue_i | input | XLEN | Address of first instruction not yet issued |
| pc_nocomplete_i | input | XLEN | Address of first instruction not completed |
| drained_i | input | 1 | Pipeline has finished its in-flight instructions |
| mem_rdy_i | input | 1 | Stack write accepted |
| mem_we_o | output | 1 | Stack write request |
| mem_addr_o | output | XLEN | Stack write byte address |
| mem_wdata_o | output | XLEN | Stack write data |
| drain_req_o | output | 1 | Request to complete in-flight instructions |
| sp_o | output | XLEN | New stack pointer, valid with done |
| sr_o | output | XLEN | New status word, valid with done |
| pc_o | output | XLEN | Handler address, valid with done |
| done_o | output | 1 | Entry complete, one cycle |

## Verification
The bench builds the block with its defaults: a 32-bit word, a 4-byte stack step and vector offsets 0x08, 0x0C and 0x10. With these, random status words can place the mask and mode bits in every combination. Random sources and random ready stalls reach the priority order, the held requests and the stalled writes. Directed cases cover the refused interrupt, the steady-high line and a request arriving while an entry is in progress.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the exception entry sequencer.
// Assumes the status word is at least 29 bits wide.
package exc_entry_pkg;
    localparam int NSRC        = 3;   // number of request sources
    localparam int SRC_DBUS    = 0;   // highest priority
    localparam int SRC_IBUS    = 1;
    localparam int SRC_NMI     = 2;   // lowest priority
    localparam int SR_R_BIT    = 15;
    localparam int SR_GM_BIT   = 16;
    localparam int SR_EM_BIT   = 21;
    localparam int SR_MODE_LSB = 22;
    localparam int SR_MODE_W   = 3;
    localparam int SR_J_BIT    = 28;
    localparam logic [SR_MODE_W-1:0] MODE_BUSERR = 3'b110;
    localparam logic [SR_MODE_W-1:0] MODE_NMI    = 3'b111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_PUSH_RET,
        ST_PUSH_SR,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/exc_req_arbiter.sv
// Pending-flag store and fixed-priority pick for the request sources.
// Index 0 wins over higher indices. A flag sets on its request and
// clears on its clear strobe. When both occur in one cycle, set wins.
module exc_req_arbiter #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] grant_o
);
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_flag
            // Hold one pending request per source.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_o[g] <= 1'b0;
                else
                    pend_o[g] <= (pend_o[g] & ~clr_i[g]) | set_i[g];
            end
        end
    endgenerate

    // Grant the lowest-index pending source.
    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_o[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/exc_sr_builder.sv
// Builds the status word presented on entry. It clears the R and J
// bits, sets the EM and GM bits and writes the mode field by source.
// Assumes XLEN covers every status bit position in the package.
module exc_sr_builder
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] sr_old_i,
    input  logic            is_nmi_i,
    output logic [XLEN-1:0] sr_new_o
);
    // Rewrite the status word fields.
    always_comb begin
        sr_new_o            = sr_old_i;
        sr_new_o[SR_R_BIT]  = 1'b0;
        sr_new_o[SR_J_BIT]  = 1'b0;
        sr_new_o[SR_EM_BIT] = 1'b1;
        sr_new_o[SR_GM_BIT] = 1'b1;
        sr_new_o[SR_MODE_LSB +: SR_MODE_W] = is_nmi_i ? MODE_NMI : MODE_BUSERR;
    end
endmodule

// File: rtl/exc_entry_fsm.sv
// Entry sequencer. In idle it takes the granted source and latches the
// stack pointer, status word, vector base and return address. For the
// interrupt it drains the pipeline first. It then makes two
// ready-handshaked stack writes and signals done for one cycle.
// Assumes grant_i is one-hot or zero.
module exc_entry_fsm
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int SP_STEP  = 4,
    parameter int VEC_DBUS = 8,
    parameter int VEC_IBUS = 12,
    parameter int VEC_NMI  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] grant_i,
    input  logic [XLEN-1:0] sr_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] evba_i,
    input  logic [XLEN-1:0] pc_noissue_i,
    input  logic [XLEN-1:0] pc_nocomplete_i,
    input  logic            drained_i,
    input  logic            mem_rdy_i,
    output logic [NSRC-1:0] clr_o,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    output logic            drain_req_o,
    output logic [XLEN-1:0] sp_o,
    output logic [XLEN-1:0] sr_old_o,
    output logic            is_nmi_o,
    output logic [XLEN-1:0] pc_o,
    output logic            done_o
);
    localparam logic [XLEN-1:0] STEP1 = XLEN'(SP_STEP);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * SP_STEP);

    seq_state_e      state_q;
    logic [NSRC-1:0] src_q;
    logic [XLEN-1:0] sp_q, sr_q, evba_q, ret_q;

    // Advance the entry sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:     if (|grant_i) state_q <= grant_i[SRC_NMI] ? ST_DRAIN : ST_PUSH_RET;
                ST_DRAIN:    if (drained_i) state_q <= ST_PUSH_RET;
                ST_PUSH_RET: if (mem_rdy_i) state_q <= ST_PUSH_SR;
                ST_PUSH_SR:  if (mem_rdy_i) state_q <= ST_DONE;
                ST_DONE:     state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the context of the selected request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            sp_q   <= '0;
            sr_q   <= '0;
            evba_q <= '0;
            ret_q  <= '0;
        end else if (state_q == ST_IDLE && |grant_i) begin
            src_q  <= grant_i;
            sp_q   <= sp_i;
            sr_q   <= sr_i;
            evba_q <= evba_i;
            ret_q  <= pc_noissue_i;
        end else if (state_q == ST_DRAIN && drained_i) begin
            ret_q  <= pc_nocomplete_i;
        end
    end

    // Drive the stack write port and the handshake strobes.
    always_comb begin
        mem_we_o    = (state_q == ST_PUSH_RET) || (state_q == ST_PUSH_SR);
        mem_addr_o  = (state_q == ST_PUSH_SR) ? (sp_q - STEP2) : (sp_q - STEP1);
        mem_wdata_o = (state_q == ST_PUSH_SR) ? sr_q : ret_q;
        drain_req_o = (state_q == ST_DRAIN);
        done_o      = (state_q == ST_DONE);
        clr_o       = done_o ? src_q : '0;
    end

    // Form the results presented with done.
    always_comb begin
        sp_o     = sp_q - STEP2;
        sr_old_o = sr_q;
        is_nmi_o = src_q[SRC_NMI];
        if (src_q[SRC_DBUS])
            pc_o = evba_q + XLEN'(VEC_DBUS);
        else if (src_q[SRC_IBUS])
            pc_o = evba_q + XLEN'(VEC_IBUS);
        else
            pc_o = evba_q + XLEN'(VEC_NMI);
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Top of the exception entry sequencer. It captures the interrupt on a
// rising edge unless the mode field shows interrupt service. It then
// arbitrates the pending sources and runs the entry sequence.
// Assumes evba_i and sp_i are stable from the request until done.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int SP_STEP  = 4,
    parameter int VEC_DBUS = 8,
    parameter int VEC_IBUS = 12,
    parameter int VEC_NMI  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbus_err_i,
    input  logic            ibus_err_i,
    input  logic            nmi_i,
    input  logic [XLEN-1:0] sr_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] evba_i,
    input  logic [XLEN-1:0] pc_noissue_i,
    input  logic [XLEN-1:0] pc_nocomplete_i,
    input  logic            drained_i,
    input  logic            mem_rdy_i,
    output logic            mem_we_o,
    output logic [XLEN-1:0] mem_addr_o,
    output logic [XLEN-1:0] mem_wdata_o,
    output logic            drain_req_o,
    output logic [XLEN-1:0] sp_o,
    output logic [XLEN-1:0] sr_o,
    output logic [XLEN-1:0] pc_o,
    output logic            done_o
);
    logic            nmi_q;
    logic            nmi_blocked;
    logic [NSRC-1:0] req_set, req_clr, pend, grant;
    logic [XLEN-1:0] sr_old;
    logic            is_nmi;

    // Remember the previous interrupt level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_q <= 1'b0;
        else
            nmi_q <= nmi_i;
    end

    // Collect new requests, dropping an interrupt edge during interrupt service.
    always_comb begin
        nmi_blocked       = (sr_i[SR_MODE_LSB +: SR_MODE_W] == MODE_NMI);
        req_set           = '0;
        req_set[SRC_DBUS] = dbus_err_i;
        req_set[SRC_IBUS] = ibus_err_i;
        req_set[SRC_NMI]  = nmi_i && !nmi_q && !nmi_blocked;
    end

    exc_req_arbiter #(.NSRC(NSRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (req_set),
        .clr_i   (req_clr),
        .pend_o  (pend),
        .grant_o (grant)
    );

    exc_entry_fsm #(
        .XLEN     (XLEN),
        .SP_STEP  (SP_STEP),
        .VEC_DBUS (VEC_DBUS),
        .VEC_IBUS (VEC_IBUS),
        .VEC_NMI  (VEC_NMI)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .grant_i         (grant),
        .sr_i            (sr_i),
        .sp_i            (sp_i),
        .evba_i          (evba_i),
        .pc_noissue_i    (pc_noissue_i),
        .pc_nocomplete_i (pc_nocomplete_i),
        .drained_i       (drained_i),
        .mem_rdy_i       (mem_rdy_i),
        .clr_o           (req_clr),
        .mem_we_o        (mem_we_o),
        .mem_addr_o      (mem_addr_o),
        .mem_wdata_o     (mem_wdata_o),
        .drain_req_o     (drain_req_o),
        .sp_o            (sp_o),
        .sr_old_o        (sr_old),
        .is_nmi_o        (is_nmi),
        .pc_o            (pc_o),
        .done_o          (done_o)
    );

    exc_sr_builder #(.XLEN(XLEN)) u_sr (
        .sr_old_i (sr_old),
        .is_nmi_i (is_nmi),
        .sr_new_o (sr_o)
    );
endmodule

// File: rtl/exc_entry_chk.sv
// Assertion checker for the exception entry sequencer. It is bound to
// the top module and observes only its ports.
module exc_entry_chk
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int VEC_DBUS = 8,
    parameter int VEC_IBUS = 12,
    parameter int VEC_NMI  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_we_o,
    input logic            mem_rdy_i,
    input logic [XLEN-1:0] mem_addr_o,
    input logic [XLEN-1:0] mem_wdata_o,
    input logic            drain_req_o,
    input logic            done_o,
    input logic [XLEN-1:0] sr_o,
    input logic [XLEN-1:0] pc_o,
    input logic [XLEN-1:0] evba_i
);
    logic [XLEN-1:0] vec_off;
    logic [SR_MODE_W-1:0] mode_out;
    assign vec_off  = pc_o - evba_i;
    assign mode_out = sr_o[SR_MODE_LSB +: SR_MODE_W];

    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && !mem_rdy_i |=> mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_DRAIN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req_o |-> !mem_we_o); // R8
    AST_SR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sr_o[SR_EM_BIT] && sr_o[SR_GM_BIT] && !sr_o[SR_R_BIT] && !sr_o[SR_J_BIT]); // R3
    AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mode_out == MODE_BUSERR) || (mode_out == MODE_NMI)); // R4
    AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (vec_off == XLEN'(VEC_DBUS)) || (vec_off == XLEN'(VEC_IBUS)) || (vec_off == XLEN'(VEC_NMI))); // R1
    AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (mode_out == MODE_NMI) |-> vec_off == XLEN'(VEC_NMI)); // R1
endmodule

bind exc_entry_seq exc_entry_chk #(
    .XLEN(XLEN), .VEC_DBUS(VEC_DBUS), .VEC_IBUS(VEC_IBUS), .VEC_NMI(VEC_NMI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_we_o(mem_we_o), .mem_rdy_i(mem_rdy_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .drain_req_o(drain_req_o),
    .done_o(done_o), .sr_o(sr_o), .pc_o(pc_o), .evba_i(evba_i)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbus_err_i = 0, ibus_err_i = 0, nmi_i = 0;
    logic [31:0] sr_i = 0, sp_i = 0, evba_i = 0, pc_noissue_i = 0, pc_nocomplete_i = 0;
    logic        drained_i = 0, mem_rdy_i = 0;
    logic        mem_we_o, drain_req_o, done_o;
    logic [31:0] mem_addr_o, mem_wdata_o, sp_o, sr_o, pc_o;

    int nvec = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .dbus_err_i(dbus_err_i), .ibus_err_i(ibus_err_i),
        .nmi_i(nmi_i), .sr_i(sr_i), .sp_i(sp_i), .evba_i(evba_i),
        .pc_noissue_i(pc_noissue_i), .pc_nocomplete_i(pc_nocomplete_i),
        .drained_i(drained_i), .mem_rdy_i(mem_rdy_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .drain_req_o(drain_req_o),
        .sp_o(sp_o), .sr_o(sr_o), .pc_o(pc_o), .done_o(done_o)
    );

    // Expected status word from the requirement text (bits 15,16,21,24:22,28).
    function automatic logic [31:0] exp_sr(input logic [31:0] s, input int src);
        logic [31:0] r;
        r = s & ~(32'h1 << 15) & ~(32'h1 << 28) & ~(32'h7 << 22);
        r = r | (32'h1 << 16) | (32'h1 << 21);
        r = r | ((src == 2 ? 32'h7 : 32'h6) << 22);
        return r;
    endfunction

    function automatic logic [31:0] exp_pc(input logic [31:0] base, input int src);
        return base + (src == 0 ? 32'h8 : (src == 1 ? 32'hC : 32'h10));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    // Follow one entry from request to done and check every output.
    task automatic serve(input int src);
        int          wc = 0;
        int          cyc = 0;
        bit          got_done = 0;
        bit          drained = 0;
        bit          saw_drain = 0;
        bit          early_we = 0;
        logic [31:0] ret_exp;
        logic [31:0] sr_at;
        sr_at   = sr_i;
        ret_exp = pc_noissue_i;
        while (!got_done && cyc < 400) begin
            @(negedge clk);
            cyc++;
            mem_rdy_i = (($urandom % 3) != 0);
            drained_i = 1'b0;
            #1;
            if (drain_req_o) begin
                saw_drain = 1;
                if (!drained && (($urandom % 4) == 0)) begin
                    pc_nocomplete_i = $urandom & 32'hFFFF_FFFE;
                    ret_exp   = pc_nocomplete_i;
                    drained_i = 1'b1;
                    drained   = 1;
                end
            end
            if (mem_we_o) begin
                if (src == 2 && !drained) early_we = 1;
                if (mem_rdy_i) begin
                    wc++;
                    if (wc == 1) begin
                        chk(mem_addr_o == sp_i - 32'd4, "R2", "first push address", mem_addr_o, sp_i - 32'd4);
                        chk(mem_wdata_o == ret_exp, src == 2 ? "R8" : "R7", "return address", mem_wdata_o, ret_exp);
                    end else begin
                        chk(mem_addr_o == sp_i - 32'd8, "R2", "second push address", mem_addr_o, sp_i - 32'd8);
                        chk(mem_wdata_o == sr_at, "R2", "pushed status", mem_wdata_o, sr_at);
                    end
                end
            end
            if (done_o) begin
                got_done = 1;
                chk(wc == 2, "R2", "write count", wc, 2);
                chk(sp_o == sp_i - 32'd8, "R2", "new stack pointer", sp_o, sp_i - 32'd8);
                chk(sr_o == exp_sr(sr_at, src), src == 2 ? "R4" : "R3", "new status", sr_o, exp_sr(sr_at, src));
                chk(pc_o == exp_pc(evba_i, src), src == 1 ? "R9" : "R1", "handler address", pc_o, exp_pc(evba_i, src));
            end
        end
        chk(got_done, "R11", "done reached", got_done, 1);
        if (src == 2) begin
            chk(saw_drain, "R8", "drain requested", saw_drain, 1);
            chk(!early_we, "R8", "write before drain", early_we, 0);
        end else begin
            chk(!saw_drain, "R7", "no drain for bus error", saw_drain, 0);
        end
        @(negedge clk);
        mem_rdy_i = 1'b0;
        drained_i = 1'b0;
        #1;
        chk(!done_o, "R11", "done is one cycle", done_o, 0);
    endtask

    // Watch n cycles with the port ready and expect no activity.
    task automatic quiet(input int n, input string req);
        int act = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mem_rdy_i = 1'b1;
            drained_i = 1'b1;
            #1;
            if (mem_we_o || drain_req_o || done_o) act++;
        end
        mem_rdy_i = 1'b0;
        drained_i = 1'b0;
        chk(act == 0, req, "idle cycles with activity", act, 0);
    endtask

    // Raise the chosen requests for one cycle (the interrupt may be held high).
    task automatic pulse(input logic [2:0] m, input bit hold_nmi);
        @(negedge clk);
        dbus_err_i = m[0];
        ibus_err_i = m[1];
        if (m[2]) nmi_i = 1'b1;
        @(negedge clk);
        dbus_err_i = 1'b0;
        ibus_err_i = 1'b0;
        if (!hold_nmi) nmi_i = 1'b0;
    endtask

    task automatic new_context(input bit clear_mode);
        sr_i = $urandom;
        if (clear_mode) sr_i[24:22] = 3'b000;
        sp_i            = ($urandom & 32'h0FFF_FFFC) | 32'h0001_0000;
        evba_i          = $urandom & 32'hFFFF_FF00;
        pc_noissue_i    = $urandom & 32'hFFFF_FFFE;
        pc_nocomplete_i = $urandom & 32'hFFFF_FFFE;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1DEA));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!mem_we_o && !drain_req_o && !done_o, "R11", "reset state",
            {29'd0, mem_we_o, drain_req_o, done_o}, 0);

        // R5: interrupt with global mask set.
        new_context(1);
        sr_i[16] = 1'b1;
        pulse(3'b100, 0);
        serve(2);

        // R9: all three at once, served in priority order.
        new_context(1);
        pulse(3'b111, 0);
        serve(0);
        serve(1);
        serve(2);

        // R13: fetch error arriving during a data-error entry.
        new_context(1);
        pulse(3'b001, 0);
        repeat (3) @(negedge clk);
        pulse(3'b010, 0);
        serve(0);
        serve(1);

        // R6: interrupt edge refused while mode shows interrupt service.
        new_context(0);
        sr_i[24:22] = 3'b111;
        pulse(3'b100, 0);
        quiet(20, "R6");
        sr_i[24:22] = 3'b000;
        quiet(20, "R6");

        // R12: steady high line enters only once.
        new_context(1);
        pulse(3'b100, 1);
        serve(2);
        quiet(20, "R12");
        nmi_i = 1'b0;

        // R10: writes held through long stalls (random ready inside serve).
        for (int it = 0; it < 60; it++) begin
            logic [2:0] m;
            m = 3'(($urandom % 7) + 1);
            new_context(1);
            pulse(m, 0);
            for (int s = 0; s < 3; s++)
                if (m[s]) serve(s);
            quiet(2, "R9");
        end
        finish_run();
    end
endmodule